// File: doc/BRIEF.md
# Privilege-Checked Address Segment Decoder

The block takes a 32-bit virtual address together with the current privilege mode and an error-level flag and decides, in one pass, which of five fixed address windows the address falls in and whether the current mode may use it. Two kernel-only windows translate straight to a physical address by subtracting their base. The low user window becomes an identity mapping while the error-level flag is set. In every such case the answer comes back one cycle after the request, with both read and write permission.

Mapped windows are forwarded to an external translation lookaside buffer over a small valid/response handshake. The decoder holds the lookup steady until the TLB answers, then returns the TLB's physical address, result code and permissions unchanged. It takes no new request while a lookup is outstanding. An access from a mode that may not use the window becomes an address error, with a load code for reads and a store code for writes.

Top module: `addr_seg_decoder`

## Requirements
- R1: An address below 0x80000000 with `err_level` high responds on the cycle after acceptance with `rsp_paddr` equal to the address, code 0 (ok), and both `rsp_rd` and `rsp_wr` high, in any mode.
- R2: An address below 0x80000000 with `err_level` low raises `tlb_req_valid` on the cycle after acceptance, carrying the address and write flag, and gives no response until the TLB answers.
- R3: In kernel mode (`priv_mode` 00), an address in 0x80000000..0x9FFFFFFF responds after one cycle with the address minus 0x80000000, code 0, read and write permitted.
- R4: In kernel mode, an address in 0xA0000000..0xBFFFFFFF responds after one cycle with the address minus 0xA0000000, code 0, read and write permitted.
- R5: From supervisor (01) or user (10) mode, an address in 0x80000000..0xBFFFFFFF gives an address error.
- R6: An address in 0xC0000000..0xDFFFFFFF goes to the TLB from kernel or supervisor mode and gives an address error from user mode.
- R7: An address at or above 0xE0000000 goes to the TLB from kernel mode only and gives an address error from any other mode.
- R8: `priv_mode` 11 behaves exactly as user mode.
- R9: While `tlb_req_valid` is high, its address and write flag stay stable until `tlb_rsp_valid`. On the cycle after `tlb_rsp_valid` is seen, the decoder responds with the TLB's physical address, code and permissions unchanged.
- R10: An address error responds one cycle after acceptance with code 2 for a write or code 1 for a read, `rsp_paddr` zero and no permissions.
- R11: `req_ready` is low while a TLB lookup is outstanding, and `req_valid` has no effect then.
- R12: In reset, `rsp_valid` and `tlb_req_valid` are low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_vaddr | input | 32 | Virtual address |
| req_write | input | 1 | 1 = store, 0 = load |
| priv_mode | input | 2 | 00 kernel, 01 supervisor, 10/11 user |
| err_level | input | 1 | Error-level flag |
| req_ready | output | 1 | Decoder idle, request taken when valid |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_paddr | output | 32 | Physical address |
| rsp_code | output | 3 | 0 ok, 1 load address error, 2 store address error, other values from the TLB |
| rsp_rd | output | 1 | Read permitted |
| rsp_wr | output | 1 | Write permitted |
| tlb_req_valid | output | 1 | TLB lookup outstanding |
| tlb_req_vaddr | output | 32 | Address under lookup |
| tlb_req_write | output | 1 | Write flag of the lookup |
| tlb_rsp_valid | input | 1 | TLB result present |
| tlb_rsp_paddr | input | 32 | TLB physical address |
| tlb_rsp_code | input | 3 | TLB result code |
| tlb_rsp_rd | input | 1 | TLB read permission |
| tlb_rsp_wr | input | 1 | TLB write permission |

## Verification
On every cycle, the assertions check the handshake timing. A direct or faulting request answers on the next cycle, and a mapped request moves to the lookup state instead of answering. The lookup stays stable until the TLB replies, the TLB's values pass through unchanged, `req_ready` drops while busy, and the kernel-only windows refuse other modes. The window boundaries, the exact subtracted addresses, the treatment of mode 11 and the rejection of requests during a lookup are shown only by the bench scenarios. There, a behavioural model is compared with the ports on every clock.

// File: rtl/seg_pkg.sv
package seg_pkg;
  localparam int unsigned VA_W   = 32;
  localparam int unsigned CODE_W = 3;
  localparam int unsigned SEL_W  = 3;
  localparam int unsigned OFS_W  = VA_W - SEL_W;

  typedef logic [VA_W-1:0]   va_t;
  typedef logic [CODE_W-1:0] code_t;

  typedef enum logic [2:0] {
    SEG_USER,
    SEG_KDIR_CACHED,
    SEG_KDIR_UNCACHED,
    SEG_SUPMAP,
    SEG_KMAP
  } seg_t;

  localparam code_t RC_OK     = code_t'(0);
  localparam code_t RC_ADE_LD = code_t'(1);
  localparam code_t RC_ADE_ST = code_t'(2);

  function automatic seg_t seg_of(va_t va);
    casez (va[VA_W-1 -: SEL_W])
      3'b0??:  return SEG_USER;
      3'b100:  return SEG_KDIR_CACHED;
      3'b101:  return SEG_KDIR_UNCACHED;
      3'b110:  return SEG_SUPMAP;
      default: return SEG_KMAP;
    endcase
  endfunction

  function automatic va_t window_base(seg_t s);
    case (s)
      SEG_KDIR_CACHED:   return {3'b100, {OFS_W{1'b0}}};
      SEG_KDIR_UNCACHED: return {3'b101, {OFS_W{1'b0}}};
      default:           return '0;
    endcase
  endfunction

  function automatic code_t fault_code(logic is_write);
    return is_write ? RC_ADE_ST : RC_ADE_LD;
  endfunction
endpackage

// File: rtl/seg_classify.sv
module seg_classify
  import seg_pkg::*;
(
  input  va_t        va,
  input  logic [1:0] priv,
  input  logic       erl,
  output logic       cls_mapped,
  output logic       cls_fault,
  output va_t        cls_paddr,
  output logic       cls_rd,
  output logic       cls_wr
);
  logic is_kern;
  logic is_sup;
  seg_t seg;

  assign is_kern = (priv == 2'b00);
  assign is_sup  = (priv == 2'b01);
  assign seg     = seg_of(va);

  always_comb begin
    cls_mapped = 1'b0;
    cls_fault  = 1'b0;
    cls_paddr  = '0;
    cls_rd     = 1'b0;
    cls_wr     = 1'b0;
    case (seg)
      SEG_USER: begin
        if (erl) begin
          cls_paddr = va;
          cls_rd    = 1'b1;
          cls_wr    = 1'b1;
        end else begin
          cls_mapped = 1'b1;
        end
      end
      SEG_KDIR_CACHED, SEG_KDIR_UNCACHED: begin
        if (is_kern) begin
          cls_paddr = va - window_base(seg);
          cls_rd    = 1'b1;
          cls_wr    = 1'b1;
        end else begin
          cls_fault = 1'b1;
        end
      end
      SEG_SUPMAP: begin
        if (is_kern || is_sup) cls_mapped = 1'b1;
        else                   cls_fault  = 1'b1;
      end
      default: begin
        if (is_kern) cls_mapped = 1'b1;
        else         cls_fault  = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/seg_sequencer.sv
module seg_sequencer
  import seg_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  req_valid,
  input  va_t   req_vaddr,
  input  logic  req_write,
  input  logic  cls_mapped,
  input  logic  cls_fault,
  input  va_t   cls_paddr,
  input  logic  cls_rd,
  input  logic  cls_wr,
  output logic  req_ready,
  output logic  tlb_req_valid,
  output va_t   tlb_req_vaddr,
  output logic  tlb_req_write,
  input  logic  tlb_rsp_valid,
  input  va_t   tlb_rsp_paddr,
  input  code_t tlb_rsp_code,
  input  logic  tlb_rsp_rd,
  input  logic  tlb_rsp_wr,
  output logic  rsp_valid,
  output va_t   rsp_paddr,
  output code_t rsp_code,
  output logic  rsp_rd,
  output logic  rsp_wr
);
  typedef enum logic {ST_IDLE, ST_WAIT} state_t;
  state_t state_q;

  logic accept_fire;
  logic tlb_done;

  assign req_ready     = (state_q == ST_IDLE);
  assign accept_fire   = req_valid && req_ready;
  assign tlb_done      = (state_q == ST_WAIT) && tlb_rsp_valid;
  assign tlb_req_valid = (state_q == ST_WAIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q       <= ST_IDLE;
      tlb_req_vaddr <= '0;
      tlb_req_write <= 1'b0;
      rsp_valid     <= 1'b0;
      rsp_paddr     <= '0;
      rsp_code      <= RC_OK;
      rsp_rd        <= 1'b0;
      rsp_wr        <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      if (accept_fire) begin
        if (cls_mapped) begin
          state_q       <= ST_WAIT;
          tlb_req_vaddr <= req_vaddr;
          tlb_req_write <= req_write;
        end else begin
          rsp_valid <= 1'b1;
          rsp_paddr <= cls_paddr;
          rsp_code  <= cls_fault ? fault_code(req_write) : RC_OK;
          rsp_rd    <= cls_rd;
          rsp_wr    <= cls_wr;
        end
      end else if (tlb_done) begin
        state_q   <= ST_IDLE;
        rsp_valid <= 1'b1;
        rsp_paddr <= tlb_rsp_paddr;
        rsp_code  <= tlb_rsp_code;
        rsp_rd    <= tlb_rsp_rd;
        rsp_wr    <= tlb_rsp_wr;
      end
    end
  end

  assert_direct_onecycle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    accept_fire && !cls_mapped |=> rsp_valid);

  assert_mapped_defer_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept_fire && cls_mapped |=> tlb_req_valid && !rsp_valid);

  assert_fault_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
    accept_fire && cls_fault |=>
      rsp_code == ($past(req_write) ? RC_ADE_ST : RC_ADE_LD) && !rsp_rd && !rsp_wr);

  assert_tlb_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tlb_req_valid && !tlb_rsp_valid |=>
      tlb_req_valid && $stable(tlb_req_vaddr) && $stable(tlb_req_write));

  assert_tlb_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tlb_req_valid && tlb_rsp_valid |=>
      rsp_valid && rsp_paddr == $past(tlb_rsp_paddr) && rsp_code == $past(tlb_rsp_code));

  assert_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    tlb_req_valid |-> !req_ready);
endmodule

// File: rtl/addr_seg_decoder.sv
module addr_seg_decoder
  import seg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic              req_write,
  input  logic [1:0]        priv_mode,
  input  logic              err_level,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [VA_W-1:0]   rsp_paddr,
  output logic [CODE_W-1:0] rsp_code,
  output logic              rsp_rd,
  output logic              rsp_wr,
  output logic              tlb_req_valid,
  output logic [VA_W-1:0]   tlb_req_vaddr,
  output logic              tlb_req_write,
  input  logic              tlb_rsp_valid,
  input  logic [VA_W-1:0]   tlb_rsp_paddr,
  input  logic [CODE_W-1:0] tlb_rsp_code,
  input  logic              tlb_rsp_rd,
  input  logic              tlb_rsp_wr
);
  logic cls_mapped, cls_fault, cls_rd, cls_wr;
  va_t  cls_paddr;

  seg_classify u_cls (
    .va         (req_vaddr),
    .priv       (priv_mode),
    .erl        (err_level),
    .cls_mapped (cls_mapped),
    .cls_fault  (cls_fault),
    .cls_paddr  (cls_paddr),
    .cls_rd     (cls_rd),
    .cls_wr     (cls_wr)
  );

  seg_sequencer u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_vaddr     (req_vaddr),
    .req_write     (req_write),
    .cls_mapped    (cls_mapped),
    .cls_fault     (cls_fault),
    .cls_paddr     (cls_paddr),
    .cls_rd        (cls_rd),
    .cls_wr        (cls_wr),
    .req_ready     (req_ready),
    .tlb_req_valid (tlb_req_valid),
    .tlb_req_vaddr (tlb_req_vaddr),
    .tlb_req_write (tlb_req_write),
    .tlb_rsp_valid (tlb_rsp_valid),
    .tlb_rsp_paddr (tlb_rsp_paddr),
    .tlb_rsp_code  (tlb_rsp_code),
    .tlb_rsp_rd    (tlb_rsp_rd),
    .tlb_rsp_wr    (tlb_rsp_wr),
    .rsp_valid     (rsp_valid),
    .rsp_paddr     (rsp_paddr),
    .rsp_code      (rsp_code),
    .rsp_rd        (rsp_rd),
    .rsp_wr        (rsp_wr)
  );

  logic in_kdir, in_kmap, not_kern;
  assign in_kdir  = (req_vaddr[VA_W-1 -: 2] == 2'b10);
  assign in_kmap  = (req_vaddr[VA_W-1 -: SEL_W] == 3'b111);
  assign not_kern = (priv_mode != 2'b00);

  assert_kdir_priv_R5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && in_kdir && not_kern |=> rsp_valid && rsp_code != RC_OK);

  assert_kmap_priv_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && in_kmap && not_kern |=> rsp_valid && !tlb_req_valid);
endmodule

// File: tb/tb_addr_seg_decoder.sv
module tb_addr_seg_decoder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, err_level = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic [1:0]  priv_mode = 2'b00;
  logic req_ready, rsp_valid, rsp_rd, rsp_wr;
  logic [31:0] rsp_paddr;
  logic [2:0]  rsp_code;
  logic tlb_req_valid, tlb_req_write;
  logic [31:0] tlb_req_vaddr;
  logic tlb_rsp_valid = 1'b0, tlb_rsp_rd = 1'b0, tlb_rsp_wr = 1'b0;
  logic [31:0] tlb_rsp_paddr = '0;
  logic [2:0]  tlb_rsp_code = '0;

  always #5 clk = ~clk;

  addr_seg_decoder dut (.*);

  int checks = 0, failures = 0, cyc = 0;
  bit done = 0;

  // behavioural reference state
  bit          m_busy = 0;
  bit [31:0]   m_va;
  bit          m_w;
  bit          e_rv = 0;
  bit [31:0]   e_pa;
  bit [2:0]    e_code;
  bit          e_rd, e_wr;
  bit          r_map;
  string       e_tag = "R12";

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic ref_classify(bit [31:0] va, bit w, bit [1:0] md, bit erl);
    bit kern, sup;
    string seg_tag;
    kern  = (md == 2'd0);
    sup   = (md == 2'd1);
    r_map = 0;
    e_pa = 0; e_code = 0; e_rd = 0; e_wr = 0;
    if (va < 32'h8000_0000) begin
      if (erl) begin e_pa = va; e_rd = 1; e_wr = 1; seg_tag = "R1"; end
      else begin r_map = 1; seg_tag = "R2"; end
    end else if (va < 32'hA000_0000) begin
      seg_tag = kern ? "R3" : "R5";
      if (kern) begin e_pa = va - 32'h8000_0000; e_rd = 1; e_wr = 1; end
      else e_code = w ? 3'd2 : 3'd1;
    end else if (va < 32'hC000_0000) begin
      seg_tag = kern ? "R4" : "R5";
      if (kern) begin e_pa = va - 32'hA000_0000; e_rd = 1; e_wr = 1; end
      else e_code = w ? 3'd2 : 3'd1;
    end else if (va < 32'hE000_0000) begin
      seg_tag = "R6";
      if (kern || sup) r_map = 1; else e_code = w ? 3'd2 : 3'd1;
    end else begin
      seg_tag = "R7";
      if (kern) r_map = 1; else e_code = w ? 3'd2 : 3'd1;
    end
    if (md == 2'd3) seg_tag = {seg_tag, ",R8"};
    if (e_code != 0) e_tag = {"R10,", seg_tag};
    else e_tag = seg_tag;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; e_rv = 0;
    end else begin
      e_rv = 0;
      if (!m_busy) begin
        if (req_valid) begin
          ref_classify(req_vaddr, req_write, priv_mode, err_level);
          if (r_map) begin m_busy = 1; m_va = req_vaddr; m_w = req_write; end
          else e_rv = 1;
        end
      end else if (tlb_rsp_valid) begin
        e_rv = 1; e_pa = tlb_rsp_paddr; e_code = tlb_rsp_code;
        e_rd = tlb_rsp_rd; e_wr = tlb_rsp_wr; e_tag = "R9"; m_busy = 0;
      end
    end
  end

  // compare with the model on every clock, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      if (!rst_n) begin
        chk(rsp_valid == 0, "R12", "rsp_valid in reset", rsp_valid, 0);
        chk(tlb_req_valid == 0, "R12", "tlb_req_valid in reset", tlb_req_valid, 0);
        chk(req_ready == 1, "R12", "req_ready in reset", req_ready, 1);
      end else begin
        chk(rsp_valid == e_rv, e_tag, "rsp_valid", rsp_valid, e_rv);
        chk(req_ready == !m_busy, "R11", "req_ready", req_ready, !m_busy);
        chk(tlb_req_valid == m_busy, "R2", "tlb_req_valid", tlb_req_valid, m_busy);
        if (m_busy) begin
          chk(tlb_req_vaddr == m_va, "R9", "tlb_req_vaddr", tlb_req_vaddr, m_va);
          chk(tlb_req_write == m_w, "R9", "tlb_req_write", tlb_req_write, m_w);
        end
        if (e_rv && rsp_valid) begin
          chk(rsp_paddr == e_pa, e_tag, "rsp_paddr", rsp_paddr, e_pa);
          chk(rsp_code == e_code, e_tag, "rsp_code", rsp_code, e_code);
          chk(rsp_rd == e_rd, e_tag, "rsp_rd", rsp_rd, e_rd);
          chk(rsp_wr == e_wr, e_tag, "rsp_wr", rsp_wr, e_wr);
        end
      end
    end
  end

  // one request; lat cycles of TLB delay, during which a stray request is offered (R11)
  task automatic send(bit [31:0] va, bit w, bit [1:0] md, bit erl, int lat, bit [2:0] tcode);
    @(negedge clk);
    req_valid = 1; req_vaddr = va; req_write = w; priv_mode = md; err_level = erl;
    @(negedge clk);
    req_valid = 0;
    if (m_busy) begin
      for (int i = 0; i < lat; i++) begin
        req_valid = 1; req_vaddr = 32'h8000_0040; priv_mode = 2'd0;
        @(negedge clk);
      end
      req_valid = 0;
      tlb_rsp_valid = 1; tlb_rsp_paddr = va ^ 32'h1234_5000; tlb_rsp_code = tcode;
      tlb_rsp_rd = 1; tlb_rsp_wr = (tcode == 0) && w;
      @(negedge clk);
      tlb_rsp_valid = 0;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      checks++; failures++;
      $display("FAIL watchdog: run hung actual=%0d expected<=20000", cyc);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    send(32'h1234_5678, 0, 2'd2, 1, 0, 0);   // R1 user, error level
    send(32'h7FFF_FFFF, 1, 2'd0, 1, 0, 0);   // R1 upper edge
    send(32'h0000_1000, 0, 2'd2, 0, 2, 0);   // R2 via TLB
    send(32'h7FFF_F000, 1, 2'd1, 0, 0, 3);   // R2 TLB miss code passes
    send(32'h8000_0000, 0, 2'd0, 0, 0, 0);   // R3 lower edge
    send(32'h9FFF_FFFF, 1, 2'd0, 0, 0, 0);   // R3 upper edge
    send(32'hA000_0000, 0, 2'd0, 0, 0, 0);   // R4
    send(32'hBFFF_FFFC, 1, 2'd0, 1, 0, 0);   // R4
    send(32'h8000_1000, 0, 2'd2, 0, 0, 0);   // R5 user load error
    send(32'hA000_2000, 1, 2'd1, 0, 0, 0);   // R5 supervisor store error
    send(32'hC000_0000, 0, 2'd1, 0, 1, 0);   // R6 supervisor mapped
    send(32'hDFFF_FFFF, 1, 2'd0, 0, 3, 5);   // R6 kernel mapped
    send(32'hC800_0000, 1, 2'd2, 0, 0, 0);   // R6 user store error
    send(32'hE000_0000, 0, 2'd0, 0, 0, 4);   // R7 kernel mapped
    send(32'hFFFF_FFFF, 0, 2'd1, 0, 0, 0);   // R7 supervisor load error
    send(32'h9000_0000, 0, 2'd3, 0, 0, 0);   // R8 mode 11 as user
    send(32'hD000_0000, 1, 2'd3, 0, 0, 0);   // R8
    send(32'h0000_0010, 0, 2'd3, 1, 0, 0);   // R8 with error level
    // back-to-back direct requests
    @(negedge clk);
    req_valid = 1; req_vaddr = 32'h8000_0100; req_write = 0; priv_mode = 2'd0; err_level = 0;
    @(negedge clk);
    req_vaddr = 32'hA000_0200; req_write = 1;
    @(negedge clk);
    req_valid = 0;
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule